// File: doc/BRIEF.md
# UART FIFO DMA Ready Signal Generator

This block drives the two active-low handshake pins that a DMA controller watches to decide when to move data into the transmit FIFO or out of the receive FIFO of a UART whose FIFOs are 64 entries deep. It takes the FIFO-enable and DMA-mode control bits, the occupancy counts of both FIFOs, the legacy transmit holding register state, and the receive trigger and timeout flags. It also takes a write strobe for the self-clearing transmit FIFO reset bit and turns it into a clear pulse for the transmit FIFO count and pointers. The transmit shift register is not part of this block and is left alone.

There are two transfer styles. In single-transfer style, each pin tracks whether one character can be moved. In multi-transfer style, the transmit pin stays active while any room is left. The receive pin latches active on a trigger or timeout event and stays active until the receive FIFO is drained completely. That gives hysteresis between the level that asserts it and the level that releases it. Both pins are registered, so each one reflects the inputs seen at the previous clock edge.

Top module: `uart_dma_rdy`

## Requirements
- R1: While rst_ni is low, tx_rdy_no is 0, rx_rdy_no is 1 and txf_clr_o is 0.
- R2: Multi-transfer style is selected only when fifo_en_i=1 and dma_mode_i=1. The other three combinations select single-transfer style.
- R3: In single-transfer style with fifo_en_i=1, tx_rdy_no is 0 one cycle after tx_cnt_i==0 and 1 one cycle after tx_cnt_i!=0. thr_full_i has no effect in this case.
- R4: In single-transfer style with fifo_en_i=0, tx_rdy_no equals the thr_full_i value sampled one cycle earlier. tx_cnt_i has no effect in this case.
- R5: In single-transfer style, rx_rdy_no is 0 one cycle after rx_cnt_i!=0 and 1 one cycle after rx_cnt_i==0. rx_trig_i and rx_tmo_i have no effect.
- R6: In multi-transfer style, tx_rdy_no is 1 one cycle after tx_cnt_i==64 and 0 one cycle after any lower count.
- R7: In multi-transfer style, rx_rdy_no goes to 0 one cycle after rx_trig_i=1 or rx_tmo_i=1.
- R8: In multi-transfer style, once rx_rdy_no is 0 it stays 0 while rx_cnt_i!=0, even after the count falls below the trigger level. It returns to 1 one cycle after rx_cnt_i==0 with neither flag set. If a flag and an empty count arrive together, the flag wins.
- R9: Each cycle in which txf_rst_wr_i=1 produces txf_clr_o=1 in the following cycle. txf_clr_o returns to 0 one cycle after the strobe drops, and it never affects tx_rdy_no or rx_rdy_no directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFOs enabled |
| dma_mode_i | input | 1 | DMA style select, 1 = multi-transfer when FIFOs are enabled |
| tx_cnt_i | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| thr_full_i | input | 1 | Legacy transmit holding register holds a character |
| rx_cnt_i | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rx_trig_i | input | 1 | Receive trigger level reached |
| rx_tmo_i | input | 1 | Receive timeout event |
| txf_rst_wr_i | input | 1 | Write of 1 to the transmit FIFO reset bit |
| tx_rdy_no | output | 1 | Transmit ready, active low |
| rx_rdy_no | output | 1 | Receive ready, active low |
| txf_clr_o | output | 1 | Clear pulse for the transmit FIFO counter and pointers |

## Verification
The hardest state to reach is the multi-transfer receive latch held active at a count that is nonzero but below the trigger level. It needs a full fill past the trigger and then a partial drain, so it cannot be reached by setting one input pattern. The bench fills the count step by step, raising the trigger flag at a chosen level. It then drains back to zero and expects the pin to stay active until the count reaches exactly zero. This is repeated for several trigger levels and for a timeout that arrives with only a few characters present. The bench also drives a flag together with an empty count to check which one takes priority.

// File: rtl/uart_dma_rdy_pkg.sv
package uart_dma_rdy_pkg;
  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_MULTI  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/dma_mode_dec.sv
module dma_mode_dec
  import uart_dma_rdy_pkg::*;
(
  input  logic       fifo_en_i,
  input  logic       dma_mode_i,
  output xfer_mode_e mode_o
);
  always_comb begin
    mode_o = (fifo_en_i && dma_mode_i) ? XFER_MULTI : XFER_SINGLE;
  end
endmodule

// File: rtl/dma_tx_rdy.sv
module dma_tx_rdy
  import uart_dma_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  xfer_mode_e       mode_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic             thr_full_i,
  output logic             tx_rdy_no
);
  localparam logic [CNT_W-1:0] FullCnt = CNT_W'(DEPTH);

  logic tx_busy_d;
  logic tx_rdy_nq;

  always_comb begin
    if (mode_i == XFER_MULTI) begin
      // active while any slot is free
      tx_busy_d = (tx_cnt_i == FullCnt);
    end else if (fifo_en_i) begin
      tx_busy_d = (tx_cnt_i != '0);
    end else begin
      tx_busy_d = thr_full_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_rdy_nq <= 1'b0;
    else         tx_rdy_nq <= tx_busy_d;
  end

  assign tx_rdy_no = tx_rdy_nq;
endmodule

// File: rtl/dma_rx_rdy.sv
module dma_rx_rdy
  import uart_dma_rdy_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  xfer_mode_e       mode_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             rx_trig_i,
  input  logic             rx_tmo_i,
  output logic             rx_rdy_no
);
  logic rx_act_q;
  logic rx_act_d;
  logic rx_nonempty;

  assign rx_nonempty = (rx_cnt_i != '0);

  always_comb begin
    if (mode_i == XFER_MULTI) begin
      // set by event, released only when drained; set wins
      rx_act_d = rx_trig_i | rx_tmo_i | (rx_act_q & rx_nonempty);
    end else begin
      rx_act_d = rx_nonempty;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_act_q <= 1'b0;
    else         rx_act_q <= rx_act_d;
  end

  assign rx_rdy_no = ~rx_act_q;
endmodule

// File: rtl/txf_rst_pulse.sv
module txf_rst_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic clr_o
);
  logic clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= wr_i;
  end

  assign clr_o = clr_q;
endmodule

// File: rtl/uart_dma_rdy.sv
module uart_dma_rdy
  import uart_dma_rdy_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic             thr_full_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             txf_rst_wr_i,
  output logic             tx_rdy_no,
  output logic             rx_rdy_no,
  output logic             txf_clr_o
);
  xfer_mode_e mode;

  dma_mode_dec u_mode (
    .fifo_en_i (fifo_en_i),
    .dma_mode_i(dma_mode_i),
    .mode_o    (mode)
  );

  dma_tx_rdy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .fifo_en_i (fifo_en_i),
    .tx_cnt_i  (tx_cnt_i),
    .thr_full_i(thr_full_i),
    .tx_rdy_no (tx_rdy_no)
  );

  dma_rx_rdy #(.CNT_W(CNT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .rx_cnt_i (rx_cnt_i),
    .rx_trig_i(rx_trig_i),
    .rx_tmo_i (rx_tmo_i),
    .rx_rdy_no(rx_rdy_no)
  );

  txf_rst_pulse u_txf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (txf_rst_wr_i),
    .clr_o (txf_clr_o)
  );
endmodule

// File: rtl/uart_dma_rdy_chk.sv
module uart_dma_rdy_chk #(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             dma_mode_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic             thr_full_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic             rx_trig_i,
  input logic             rx_tmo_i,
  input logic             txf_rst_wr_i,
  input logic             tx_rdy_no,
  input logic             rx_rdy_no,
  input logic             txf_clr_o
);
  logic multi;
  assign multi = fifo_en_i && dma_mode_i;

  // R6
  tx_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi && tx_cnt_i == CNT_W'(DEPTH)) |=> tx_rdy_no);

  // R6
  tx_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi && tx_cnt_i != CNT_W'(DEPTH)) |=> !tx_rdy_no);

  // R4
  thr_legacy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i) |=> (tx_rdy_no == $past(thr_full_i)));

  // R5
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!multi && rx_cnt_i != '0) |=> !rx_rdy_no);

  // R7
  rx_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi && (rx_trig_i || rx_tmo_i)) |=> !rx_rdy_no);

  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi && !rx_rdy_no && rx_cnt_i != '0) |=> !rx_rdy_no);

  // R8
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi && rx_cnt_i == '0 && !rx_trig_i && !rx_tmo_i) |=> rx_rdy_no);

  // R9
  clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_rst_wr_i |=> txf_clr_o);

  // R9
  clr_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txf_rst_wr_i |=> !txf_clr_o);
endmodule

bind uart_dma_rdy uart_dma_rdy_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .dma_mode_i  (dma_mode_i),
  .tx_cnt_i    (tx_cnt_i),
  .thr_full_i  (thr_full_i),
  .rx_cnt_i    (rx_cnt_i),
  .rx_trig_i   (rx_trig_i),
  .rx_tmo_i    (rx_tmo_i),
  .txf_rst_wr_i(txf_rst_wr_i),
  .tx_rdy_no   (tx_rdy_no),
  .rx_rdy_no   (rx_rdy_no),
  .txf_clr_o   (txf_clr_o)
);

// File: tb/uart_dma_rdy_tb.sv
`timescale 1ns/1ps
module uart_dma_rdy_tb;
  localparam int DEPTH = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0;
  logic       dma_mode_i = 1'b0;
  logic [6:0] tx_cnt_i = '0;
  logic       thr_full_i = 1'b0;
  logic [6:0] rx_cnt_i = '0;
  logic       rx_trig_i = 1'b0;
  logic       rx_tmo_i = 1'b0;
  logic       txf_rst_wr_i = 1'b0;
  logic       tx_rdy_no;
  logic       rx_rdy_no;
  logic       txf_clr_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  uart_dma_rdy #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        vectors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk("R1 tx", tx_rdy_no, 1'b0);
    chk("R1 rx", rx_rdy_no, 1'b1);
    chk("R1 clr", txf_clr_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // transmit sweep: R2 R3 R4 R6
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        for (int c = 0; c <= DEPTH; c++) begin
          logic exp;
          fifo_en_i  = m[1];
          dma_mode_i = m[0];
          thr_full_i = t[0];
          tx_cnt_i   = 7'(c);
          step();
          if (m == 3)      exp = (c == DEPTH);
          else if (m >= 2) exp = (c != 0);
          else             exp = t[0];
          if (m == 3)      chk("R6 R2 tx multi", tx_rdy_no, exp);
          else if (m >= 2) chk("R3 tx fifo single", tx_rdy_no, exp);
          else             chk("R4 tx legacy", tx_rdy_no, exp);
          chk("R9 no clr", txf_clr_o, 1'b0);
        end
      end
    end

    // single-transfer receive sweep, flags toggled to show no effect: R5
    for (int m = 0; m < 3; m++) begin
      for (int c = 0; c <= DEPTH; c++) begin
        fifo_en_i  = m[1];
        dma_mode_i = m[0];
        rx_cnt_i   = 7'(c);
        rx_trig_i  = c[0];
        rx_tmo_i   = c[1];
        step();
        chk("R5 rx single", rx_rdy_no, c == 0);
      end
    end
    rx_trig_i = 1'b0;
    rx_tmo_i  = 1'b0;
    rx_cnt_i  = '0;

    // multi-transfer receive hysteresis over trigger levels: R7 R8
    fifo_en_i  = 1'b1;
    dma_mode_i = 1'b1;
    step();
    chk("R8 rx idle", rx_rdy_no, 1'b1);
    for (int k = 0; k < 4; k++) begin
      int lvl;
      lvl = (k == 0) ? 1 : (k == 1) ? 8 : (k == 2) ? 16 : 56;
      for (int c = 0; c <= lvl + 4; c++) begin
        rx_cnt_i  = 7'(c);
        rx_trig_i = (c >= lvl);
        step();
        chk("R7 rx fill", rx_rdy_no, !(c >= lvl));
      end
      for (int c = lvl + 4; c >= 0; c--) begin
        rx_cnt_i  = 7'(c);
        rx_trig_i = (c >= lvl);
        step();
        chk("R8 rx drain", rx_rdy_no, c == 0);
      end
    end

    // timeout with few characters: R7 R8
    rx_cnt_i = 7'd3;
    step();
    chk("R8 rx below trig", rx_rdy_no, 1'b1);
    rx_tmo_i = 1'b1;
    step();
    chk("R7 rx timeout", rx_rdy_no, 1'b0);
    rx_tmo_i = 1'b0;
    for (int c = 2; c >= 0; c--) begin
      rx_cnt_i = 7'(c);
      step();
      chk("R8 rx tmo drain", rx_rdy_no, c == 0);
    end

    // flag together with empty count: R8 set wins
    rx_cnt_i  = '0;
    rx_trig_i = 1'b1;
    step();
    chk("R8 set priority", rx_rdy_no, 1'b0);
    rx_trig_i = 1'b0;
    step();
    chk("R8 release", rx_rdy_no, 1'b1);

    // transmit FIFO reset strobe: R9
    tx_cnt_i = 7'd10;
    txf_rst_wr_i = 1'b1;
    step();
    chk("R9 clr pulse", txf_clr_o, 1'b1);
    chk("R9 tx untouched", tx_rdy_no, 1'b0);
    chk("R9 rx untouched", rx_rdy_no, 1'b1);
    step();
    chk("R9 clr held", txf_clr_o, 1'b1);
    txf_rst_wr_i = 1'b0;
    step();
    chk("R9 clr self", txf_clr_o, 1'b0);

    // asynchronous reset mid-run: R1
    rx_cnt_i  = 7'd5;
    rx_trig_i = 1'b1;
    tx_cnt_i  = 7'd64;
    step();
    chk("R7 pre-reset", rx_rdy_no, 1'b0);
    chk("R6 pre-reset", tx_rdy_no, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async tx", tx_rdy_no, 1'b0);
    chk("R1 async rx", rx_rdy_no, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule